// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the gates of a three-phase bridge. One 12-bit counter counts up from zero to the programmed half-period minus one. It holds that value for one more cycle and then counts back down to zero. Each of the three phases compares its duty value against this counter. The result is a high-side pulse that sits symmetrically about the middle of the period. The complementary low-side output is active around the period ends.

A programmed deadtime is cut from both edges of every high-side pulse, so the two switches of a leg are never on together. A programmed minimum width suppresses any high or low pulse that would be too narrow to be useful. A one-cycle sync pulse marks the start of every period. A host writes the settings through a single-cycle register port. Every setting is double-buffered and is taken up only at a period boundary.

An external stop input forces every gate output inactive at once. It acts even while the clock is halted. The stop condition stays latched until the host clears it.

Top module: `cpwm_top`

## Requirements
- R1: With half-period value P (P = 0 is treated as 1), the counter period is exactly 2·P clock cycles, so consecutive sync pulses are 2·P cycles apart.
- R2: Every high-side pulse is centred in its period. Counting the sync cycle as index 0, the first and last active indices of a non-empty high pulse add up to 2·P − 1.
- R3: The register port has these write addresses: 0 half-period, 1/2/3 duty of phases A/B/C, 4 deadtime, 5 minimum half-width, 7 stop clear. A write during a period changes nothing until the next period begins.
- R4: Let E = min(duty, P). Each period, the high output is active for 2·max(E − deadtime, 0) cycles and the low output for 2·(P − E) cycles. The two outputs of a phase are never active in the same cycle.
- R5: The sync output is a single-cycle pulse, given once per period in the first cycle of that period.
- R6: Outputs are active-high (1 = switch on). While stop is high, all six gate outputs are 0 immediately, whether or not the clock runs.
- R7: After stop falls, the outputs stay 0 until a write to address 7. After that write, normal switching resumes.
- R8: A write to address 7 while stop is still high has no effect; the outputs stay 0.
- R9: With minimum half-width M > 0, a high or low pulse whose half-width (count per half-period) is below M is not produced at all. M = 0 disables deletion.
- R10: While reset is asserted, all gate outputs and the sync output are 0. After reset, all duties are 0, so only the low-side outputs switch on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 12 | Register write data |
| stop_i | input | 1 | Asynchronous shutdown, active high |
| sync_o | output | 1 | Period start pulse |
| hi_o | output | 3 | High-side gate drives, bit 0 = phase A |
| lo_o | output | 3 | Low-side gate drives, bit 0 = phase A |

## Verification
The clocked checks on stop assume that stop changes well away from a rising clock edge. They also assume that a clear write and a falling stop never fall on the same edge. The bench moves stop only shortly after falling edges, or while the clock is halted, and it separates stop and clear in time. The non-overlap and buffering checks assume writes arrive as single-cycle strobes. The bench's write task always produces exactly one such strobe per write. Half-period values stay small so that each period can be measured whole.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int NPH = 3;
  localparam int AW  = 3;
  localparam logic [AW-1:0] ADR_PER   = 3'd0;
  localparam logic [AW-1:0] ADR_DUTY0 = 3'd1;
  localparam logic [AW-1:0] ADR_DEAD  = 3'd4;
  localparam logic [AW-1:0] ADR_MINW  = 3'd5;
  localparam logic [AW-1:0] ADR_CLR   = 3'd7;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CW      = 12,
  parameter int DEF_PER = 250
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    load,
  output logic [CW-1:0]           per_s,
  output logic [NPH-1:0][CW-1:0]  duty_s,
  output logic [CW-1:0]           dead_s,
  output logic [CW-1:0]           minw_s,
  output logic                    clr_stop
);
  localparam logic [CW-1:0] PER_RST = CW'(DEF_PER);

  logic [CW-1:0]          per_a, per_d, dead_a, dead_d, minw_a, minw_d;
  logic [NPH-1:0][CW-1:0] duty_a, duty_d;

  always_comb begin
    per_d  = per_a;
    duty_d = duty_a;
    dead_d = dead_a;
    minw_d = minw_a;
    if (wr_en) begin
      if (wr_addr == ADR_PER)  per_d  = wr_data;
      if (wr_addr == ADR_DEAD) dead_d = wr_data;
      if (wr_addr == ADR_MINW) minw_d = wr_data;
      for (int p = 0; p < NPH; p++) begin
        if (wr_addr == AW'(int'(ADR_DUTY0) + p)) duty_d[p] = wr_data;
      end
    end
  end

  assign clr_stop = wr_en && (wr_addr == ADR_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_a  <= PER_RST;
      duty_a <= '0;
      dead_a <= '0;
      minw_a <= '0;
    end else begin
      per_a  <= per_d;
      duty_a <= duty_d;
      dead_a <= dead_d;
      minw_a <= minw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_s  <= PER_RST;
      duty_s <= '0;
      dead_s <= '0;
      minw_s <= '0;
    end else if (load) begin
      per_s  <= per_a;
      duty_s <= duty_a;
      dead_s <= dead_a;
      minw_s <= minw_a;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(per_s) && $stable(duty_s) && $stable(dead_s) && $stable(minw_s))); // R3
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] per_s,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] per_eff,
  output logic          load,
  output logic          start
);
  logic          up, up_d;
  logic [CW-1:0] cnt_d;

  assign per_eff = (per_s == '0) ? CW'(1) : per_s;
  assign load    = !up && (cnt == '0);
  assign start   = up && (cnt == '0);

  always_comb begin
    cnt_d = cnt;
    up_d  = up;
    if (up) begin
      if (cnt >= per_eff - CW'(1)) up_d = 1'b0;
      else                         cnt_d = cnt + CW'(1);
    end else begin
      if (cnt == '0) up_d = 1'b1;
      else           cnt_d = cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= cnt_d;
      up  <= up_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per_eff); // R1
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] per_eff,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] dead,
  input  logic [CW-1:0] minw,
  output logic          hi_q,
  output logic          lo_q
);
  logic [CW-1:0] eff, hi_half, lo_half;
  logic          hi_en, lo_en, hi_d, lo_d;

  always_comb begin
    eff     = (duty > per_eff) ? per_eff : duty;
    lo_half = per_eff - eff;
    hi_half = (eff > dead) ? (eff - dead) : '0;
    hi_en   = (hi_half != '0) && (hi_half >= minw);
    lo_en   = (lo_half != '0) && (lo_half >= minw);
    hi_d    = hi_en && (cnt >= per_eff - hi_half);
    lo_d    = lo_en && (cnt < lo_half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q)); // R4
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int CW      = 12,
  parameter int DEF_PER = 250
) (
  input  logic           clk,
  input  logic           rst_n_i,
  input  logic           wr_en_i,
  input  logic [2:0]     wr_addr_i,
  input  logic [CW-1:0]  wr_data_i,
  input  logic           stop_i,
  output logic           sync_o,
  output logic [2:0]     hi_o,
  output logic [2:0]     lo_o
);
  logic [1:0]             rst_pipe;
  logic                   rst_n;
  logic [CW-1:0]          per_s, dead_s, minw_s, cnt, per_eff;
  logic [NPH-1:0][CW-1:0] duty_s;
  logic                   load, start, clr_stop, stop_l, sync_q;
  logic [NPH-1:0]         hi_v, lo_v;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe <= 2'b00;
    else          rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  cpwm_regs #(.CW(CW), .DEF_PER(DEF_PER)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .load(load), .per_s(per_s), .duty_s(duty_s),
    .dead_s(dead_s), .minw_s(minw_s), .clr_stop(clr_stop));

  cpwm_counter #(.CW(CW)) i_cnt (
    .clk(clk), .rst_n(rst_n), .per_s(per_s), .cnt(cnt),
    .per_eff(per_eff), .load(load), .start(start));

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    cpwm_phase #(.CW(CW)) i_ph (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .per_eff(per_eff),
      .duty(duty_s[p]), .dead(dead_s), .minw(minw_s),
      .hi_q(hi_v[p]), .lo_q(lo_v[p]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= start;
  end

  always_ff @(posedge clk or negedge rst_n or posedge stop_i) begin
    if (!rst_n)        stop_l <= 1'b0;
    else if (stop_i)   stop_l <= 1'b1;
    else if (clr_stop) stop_l <= 1'b0;
  end

  assign sync_o = sync_q;
  assign hi_o   = hi_v & {NPH{~stop_l}};
  assign lo_o   = lo_v & {NPH{~stop_l}};

  AST_STOP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> (hi_o == '0 && lo_o == '0)); // R6
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_i) |-> (hi_o == '0 && lo_o == '0)); // R7
  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o); // R5
endmodule

// File: tb/test_cpwm_top.sv
module test_cpwm_top;
  logic       clk = 1'b0, clk_run = 1'b1;
  logic       rst_n_i, wr_en_i, stop_i;
  logic [2:0] wr_addr_i;
  logic [11:0] wr_data_i;
  logic       sync_o;
  logic [2:0] hi_o, lo_o;

  int total = 0, fails = 0;
  int m_hi [3], m_lo [3];
  int m_first, m_last, m_sync, m_ovl, m_next;

  localparam int NV = 9;
  localparam int VEC [NV][4] = '{
    '{20, 8, 2, 0}, '{20, 0, 2, 0}, '{20, 20, 2, 0}, '{20, 25, 0, 0},
    '{20, 5, 2, 4}, '{20, 18, 1, 3}, '{10, 5, 5, 0}, '{30, 10, 3, 2},
    '{1, 1, 0, 0}};

  always #5 if (clk_run) clk = ~clk;

  cpwm_top i_cpwm_top (.clk(clk), .rst_n_i(rst_n_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .stop_i(stop_i),
    .sync_o(sync_o), .hi_o(hi_o), .lo_o(lo_o));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_of(input int p, input int d);
    return (d > p) ? p : d;
  endfunction
  function automatic int hi_cnt(input int p, input int d, input int dt, input int mw);
    int h = eff_of(p, d) - dt;
    if (h < 0) h = 0;
    if (h < mw) h = 0;
    return 2 * h;
  endfunction
  function automatic int lo_cnt(input int p, input int d, input int mw);
    int l = p - eff_of(p, d);
    if (l < mw) l = 0;
    return 2 * l;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 12'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_sync();
    do @(negedge clk); while (!sync_o);
  endtask

  task automatic measure(input int pe);
    wait_sync();
    m_first = -1; m_last = -1; m_sync = 0; m_ovl = 0;
    for (int p = 0; p < 3; p++) begin m_hi[p] = 0; m_lo[p] = 0; end
    for (int j = 0; j < 2 * pe; j++) begin
      if (j > 0) @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        m_hi[p] += int'(hi_o[p]);
        m_lo[p] += int'(lo_o[p]);
      end
      if (hi_o[0]) begin
        if (m_first < 0) m_first = j;
        m_last = j;
      end
      if ((hi_o & lo_o) != 3'b000) m_ovl++;
      if (sync_o) m_sync++;
    end
    @(negedge clk);
    m_next = int'(sync_o);
  endtask

  task automatic quiet(input int n, output int act);
    act = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if ((hi_o | lo_o) != 3'b000) act++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #1_500_000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int act, pe, d, dt, mw, hexp;
    string rq;
    rst_n_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; stop_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 sync", int'(sync_o), 0);
    chk("R10 gates", int'({hi_o, lo_o}), 0);
    rst_n_i = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 default low", int'(lo_o), 7);
    chk("R10 default high", int'(hi_o), 0);

    for (int v = 0; v < NV; v++) begin
      pe = (VEC[v][0] == 0) ? 1 : VEC[v][0];
      d = VEC[v][1]; dt = VEC[v][2]; mw = VEC[v][3];
      wr(0, VEC[v][0]); wr(1, d); wr(2, d / 2); wr(3, d + 3); wr(4, dt); wr(5, mw);
      wait_sync();
      measure(pe);
      rq = (mw != 0) ? "R9" : "R4";
      chk({rq, " hiA"}, m_hi[0], hi_cnt(pe, d, dt, mw));
      chk({rq, " loA"}, m_lo[0], lo_cnt(pe, d, mw));
      chk({rq, " hiB"}, m_hi[1], hi_cnt(pe, d / 2, dt, mw));
      chk({rq, " loC"}, m_lo[2], lo_cnt(pe, d + 3, mw));
      chk({rq, " hiC"}, m_hi[2], hi_cnt(pe, d + 3, dt, mw));
      chk("R4 overlap", m_ovl, 0);
      chk("R1 period", m_next, 1);
      chk("R5 one sync", m_sync, 1);
      if (m_hi[0] > 0) chk("R2 centre", m_first + m_last, 2 * pe - 1);
    end

    // R3: mid-period duty write waits for the next period
    wr(0, 20); wr(1, 8); wr(2, 8); wr(3, 8); wr(4, 2); wr(5, 0);
    wait_sync(); wait_sync();
    wait_sync();
    wr(1, 15);
    act = 0;
    for (int j = 3; j < 40; j++) begin
      @(negedge clk);
      act += int'(hi_o[0]);
    end
    chk("R3 old duty kept", act, 12);
    measure(20);
    chk("R3 new duty", m_hi[0], 26);
    wr(1, 8);
    wait_sync(); wait_sync();

    // R6 / R7 / R8: shutdown behaviour
    wait_sync();
    @(negedge clk);
    #1 stop_i = 1'b1;
    #1 chk("R6 immediate", int'({hi_o, lo_o}), 0);
    repeat (3) @(negedge clk);
    #1 stop_i = 1'b0;
    quiet(45, act);
    chk("R7 latched", act, 0);
    #1 stop_i = 1'b1;
    wr(7, 0);
    #1 stop_i = 1'b0;
    quiet(45, act);
    chk("R8 clear ignored", act, 0);
    wr(7, 0);
    quiet(45, act);
    chk("R7 resumed", int'(act > 0), 1);

    // R6 with the clock halted
    wait_sync();
    @(negedge clk);
    clk_run = 1'b0;
    #20 stop_i = 1'b1;
    #2 chk("R6 no clock", int'({hi_o, lo_o}), 0);
    #5 stop_i = 1'b0;
    #3 clk_run = 1'b1;
    quiet(10, act);
    chk("R7 latched after halt", act, 0);
    wr(7, 0);
    measure(20);
    chk("R7 full period after clear", m_hi[0], 12);

    finish_run();
  end
endmodule